// File: doc/BRIEF.md
# Strobe-Clocked Double-Rate Read Capture FIFO

This block takes read data from a double-data-rate memory lane group and hands it to the system clock domain. The returning data strobe clocks the data bits straight into two small FIFOs, with no staging register in front of them. One FIFO takes the word present at each rising strobe edge. The other takes the word present at the following falling edge. The system side runs on a clock shifted by 90 degrees. Each FIFO has a gray-coded write pointer, and that pointer passes through two flops in the system domain before it is compared with the gray-coded read pointer.

Writes are gated by a single strobe-domain capture control. It is sampled at each rising strobe edge, and the falling-edge write of that cycle follows the value sampled there, so words always enter the two FIFOs in matched pairs. On the read side, valid is formed only from the two empty flags. Whenever both FIFOs hold data, the pair is presented and both read pointers advance on the same system clock edge. The consumer takes every valid pair and has no back-pressure.

Top module: `dqs_capture_fifo`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_valid` is low until a strobe pair is written.
- R2: The word on `dq_in` at a rising `dqs` edge appears on `rd_rise`. The word at the next falling edge appears on `rd_fall` in the same valid cycle.
- R3: The number of pairs held in a FIFO never exceeds DEPTH when the strobe rate stays within the drain rate of one pair per `clk90` cycle.
- R4: Pairs leave in the order they were written, each exactly once, with none lost.
- R5: Strobe cycles whose rising edge sees `cap_en` low write nothing into either FIFO.
- R6: `rd_valid` is high exactly when both FIFOs are non-empty. Each `clk90` cycle with `rd_valid` high pops one entry from each FIFO.
- R7: Read pointers are gray coded, so consecutive values differ in at most one bit.
- R8: A pair whose falling edge lands between two `clk90` rising edges is not visible in the cycle after that edge. It becomes visible by the second `clk90` edge that follows.
- R9: Asserting `rst_n` discards all stored pairs, so no stale pair is presented after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset. Released synchronously in the `clk90` domain. |
| dqs | input | 1 | Data strobe from memory, used as the write clock on both edges. |
| cap_en | input | 1 | Strobe-domain capture control, sampled at the rising `dqs` edge. |
| dq_in | input | DATA_W | Read data bits from the lane group. |
| clk90 | input | 1 | System clock shifted by 90 degrees; the read domain. |
| rd_rise | output | DATA_W | Word captured at the rising strobe edge. |
| rd_fall | output | DATA_W | Word captured at the falling strobe edge. |
| rd_valid | output | 1 | High when a pair is presented; the pair is consumed on this edge. |

## Verification
The bench uses DATA_W = 8 and DEPTH = 8, which gives 4-bit gray pointers. The stream of over a hundred pairs therefore wraps both pointers many times. The gray-to-binary occupancy check and the one-bit-step rule are both exercised across the wrap. Strobe periods are drawn at random, with random phase against `clk90`, ranging from slow isolated pairs to dense bursts near the drain rate. This lets the two-flop synchroniser see pointer updates at every alignment, including edges landing close to `clk90`.

// File: rtl/dqs_cap_pkg.sv
package dqs_cap_pkg;

  localparam int unsigned LANES = 2;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dqs_cap_sync.sv
module dqs_cap_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dqs_cap_lane.sv
module dqs_cap_lane
  import dqs_cap_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  output logic              empty
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned PTR_W  = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [PTR_W-1:0] wptr_bin, wptr_bin_nxt;
  logic [PTR_W-1:0] wptr_gray, wptr_gray_nxt;
  logic [PTR_W-1:0] wgray_sync;
  logic [PTR_W-1:0] rptr_bin, rptr_bin_nxt;
  logic [PTR_W-1:0] rptr_gray, rptr_gray_nxt;

  // write side, strobe domain
  always_comb begin
    wptr_bin_nxt  = wen ? wptr_bin + 1'b1 : wptr_bin;
    wptr_gray_nxt = PTR_W'(bin2gray(32'(wptr_bin_nxt)));
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else begin
      wptr_bin  <= wptr_bin_nxt;
      wptr_gray <= wptr_gray_nxt;
    end
  end

  always_ff @(posedge wclk) begin
    if (wen) mem[wptr_bin[ADDR_W-1:0]] <= wdata;
  end

  // pointer crossing into the read domain
  dqs_cap_sync #(.WIDTH(PTR_W), .STAGES(2)) i_wptr_sync (
    .clk   (rclk),
    .rst_n (rrst_n),
    .d     (wptr_gray),
    .q     (wgray_sync)
  );

  // read side, clk90 domain
  always_comb begin
    rptr_bin_nxt  = ren ? rptr_bin + 1'b1 : rptr_bin;
    rptr_gray_nxt = PTR_W'(bin2gray(32'(rptr_bin_nxt)));
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else begin
      rptr_bin  <= rptr_bin_nxt;
      rptr_gray <= rptr_gray_nxt;
    end
  end

  assign empty = (wgray_sync == rptr_gray);
  assign rdata = mem[rptr_bin[ADDR_W-1:0]];

  // assertions
  logic [PTR_W-1:0] occ_seen;
  assign occ_seen = PTR_W'(gray2bin(32'(wgray_sync))) - rptr_bin;

  p_no_overflow_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
    occ_seen <= PTR_W'(DEPTH))
    else $error("lane occupancy above depth");

  p_pop_nonempty_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    ren |-> !empty)
    else $error("pop from empty lane");

  p_rptr_gray_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    1'b1 |=> ($countones(rptr_gray ^ $past(rptr_gray)) <= 1))
    else $error("read pointer moved more than one gray bit");

endmodule

// File: rtl/dqs_capture_fifo.sv
module dqs_capture_fifo
  import dqs_cap_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              rst_n,
  input  logic              dqs,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              clk90,
  output logic [DATA_W-1:0] rd_rise,
  output logic [DATA_W-1:0] rd_fall,
  output logic              rd_valid
);

  logic              rrst_n;
  logic              pair_pend;
  logic              lane_clk   [LANES];
  logic              lane_wen   [LANES];
  logic              lane_empty [LANES];
  logic [DATA_W-1:0] lane_rdata [LANES];
  logic              pop;

  // read-domain reset: asserted at once, released through two flops
  dqs_cap_sync #(.WIDTH(1), .STAGES(2)) i_rst_sync (
    .clk   (clk90),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rrst_n)
  );

  // the falling-edge write follows the control sampled at the rising edge
  always_ff @(posedge dqs or negedge rst_n) begin
    if (!rst_n) pair_pend <= 1'b0;
    else        pair_pend <= cap_en;
  end

  assign pop = rd_valid;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    if (g == 0) begin : g_rise
      assign lane_clk[g] = dqs;
      assign lane_wen[g] = cap_en;
    end else begin : g_fall
      assign lane_clk[g] = ~dqs;
      assign lane_wen[g] = pair_pend;
    end

    dqs_cap_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_lane (
      .wclk   (lane_clk[g]),
      .wrst_n (rst_n),
      .wen    (lane_wen[g]),
      .wdata  (dq_in),
      .rclk   (clk90),
      .rrst_n (rrst_n),
      .ren    (pop),
      .rdata  (lane_rdata[g]),
      .empty  (lane_empty[g])
    );
  end

  assign rd_valid = !lane_empty[0] && !lane_empty[1];
  assign rd_rise  = lane_rdata[0];
  assign rd_fall  = lane_rdata[1];

  p_reset_idle_r1: assert property (@(posedge clk90) disable iff (!rrst_n)
    $rose(rrst_n) |-> !rd_valid)
    else $error("valid right after reset release");

endmodule

// File: tb/test_dqs_capture_fifo.sv
`timescale 1ns/1ps
module test_dqs_capture_fifo;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;

  logic              rst_n;
  logic              dqs;
  logic              cap_en;
  logic [DATA_W-1:0] dq_in;
  logic              clk90;
  logic [DATA_W-1:0] rd_rise;
  logic [DATA_W-1:0] rd_fall;
  logic              rd_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [2*DATA_W-1:0] sb_q [$];
  logic [DATA_W-1:0] seq;

  dqs_capture_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dqs_capture_fifo (
    .rst_n    (rst_n),
    .dqs      (dqs),
    .cap_en   (cap_en),
    .dq_in    (dq_in),
    .clk90    (clk90),
    .rd_rise  (rd_rise),
    .rd_fall  (rd_fall),
    .rd_valid (rd_valid)
  );

  initial clk90 = 1'b0;
  always #2 clk90 = ~clk90;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk90) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // monitor: pop and compare each presented pair (R2, R4, R6)
  always @(negedge clk90) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R6 unexpected pair", {rd_rise, rd_fall}, 0);
      end else begin
        logic [2*DATA_W-1:0] exp_pair;
        exp_pair = sb_q.pop_front();
        check({rd_rise, rd_fall} == exp_pair, "R2/R4 pair", {rd_rise, rd_fall}, exp_pair);
      end
    end
  end

  // one strobe cycle; half periods in ns
  task automatic strobe_pair(input logic [DATA_W-1:0] r, input logic [DATA_W-1:0] f,
                             input bit en, input real hi, input real lo);
    cap_en = en;
    dq_in  = r;
    #0.3;
    dqs = 1'b1;
    if (en) sb_q.push_back({r, f});
    #0.3;
    dq_in = f;
    #(hi - 0.3);
    dqs = 1'b0;
    #(lo);
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk90);
  endtask

  initial begin
    rst_n = 1'b0; dqs = 1'b0; cap_en = 1'b0; dq_in = '0; seq = 8'h10;
    wait_clks(3);
    check(rd_valid == 1'b0, "R1 valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    wait_clks(4);
    check(rd_valid == 1'b0, "R1 valid after release", rd_valid, 0);

    // R8: sync latency of one pair
    @(posedge clk90);
    #0.5;
    cap_en = 1'b1; dq_in = 8'hA5; sb_q.push_back({8'hA5, 8'h5A});
    #0.3; dqs = 1'b1;
    #0.3; dq_in = 8'h5A;
    #1.0; dqs = 1'b0;
    cap_en = 1'b0;
    @(negedge clk90);
    check(rd_valid == 1'b0, "R8 visible too early", rd_valid, 0);
    @(posedge clk90); #1;
    check(rd_valid == 1'b1, "R8 not visible after two edges", rd_valid, 1);
    wait_clks(4);

    // R5: strobe cycles with capture off
    for (int i = 0; i < 4; i++) strobe_pair(8'hEE, 8'hDD, 1'b0, 3.0, 3.0);
    wait_clks(8);
    check(rd_valid == 1'b0, "R5 disabled strobes wrote", rd_valid, 0);
    check(sb_q.size() == 0, "R5 scoreboard", sb_q.size(), 0);

    // slow pairs, random phase (R2, R4, R7)
    for (int i = 0; i < 60; i++) begin
      #($urandom_range(0, 900) / 100.0);
      strobe_pair(seq, ~seq, 1'b1, 3.0 + $urandom_range(0, 300) / 100.0,
                  3.0 + $urandom_range(0, 300) / 100.0);
      seq++;
    end
    wait_clks(8);

    // dense bursts near the drain rate (R3, R4)
    for (int b = 0; b < 8; b++) begin
      #($urandom_range(0, 400) / 100.0);
      for (int i = 0; i < 6; i++) begin
        strobe_pair(seq, seq ^ 8'h3C, 1'b1, 2.6, 2.6 + $urandom_range(0, 50) / 100.0);
        seq++;
      end
      // a disabled cycle mid-stream must not add a pair (R5)
      strobe_pair(8'hFF, 8'h00, 1'b0, 2.6, 2.6);
      wait_clks(12);
    end
    check(sb_q.size() == 0, "R4 pairs lost", sb_q.size(), 0);

    // R9: reset while pairs are in flight
    for (int i = 0; i < 3; i++) begin
      strobe_pair(seq, seq, 1'b1, 2.6, 2.6);
      seq++;
    end
    rst_n = 1'b0;
    sb_q.delete();
    wait_clks(3);
    check(rd_valid == 1'b0, "R9 valid during reset", rd_valid, 0);
    rst_n = 1'b1;
    wait_clks(10);
    check(rd_valid == 1'b0, "R9 stale pair after reset", rd_valid, 0);

    // traffic resumes after reset
    for (int i = 0; i < 10; i++) begin
      strobe_pair(seq, ~seq, 1'b1, 4.0, 4.0);
      seq++;
    end
    wait_clks(10);
    check(sb_q.size() == 0, "R4 pairs lost after reset", sb_q.size(), 0);
    check(rd_valid == 1'b0, "R6 valid with both lanes drained", rd_valid, 0);
    finish_run();
  end

endmodule